// File: doc/BRIEF.md
# Time-Slot Serial Loop Coupler

This block sits between a device and a framed serial loop. The loop carries frames of 256 slots, and each slot is 36 bits long. A slot word is a 4-bit supervisory code followed by a 32-bit operand. A framing pulse arrives with the first bit of slot 0. From that pulse the coupler counts bits and slots, so it knows which slot is passing at every bit time. A configured base slot and a share mode pick the slots that belong to the device. The device may own 1, 8, 16 or 32 slots, spread evenly around the frame.

In an owned slot, the coupler captures the incoming word and presents it in parallel, together with a decoded command kind. On the same bit times it replaces the outgoing bits with a word taken from the device, or with an idle word if the device has nothing ready. In every other slot, each bit is repeated onto the outgoing line one bit time later.

The block works on a recovered bit clock: a qualifier marks each clock cycle that carries one line bit. The device transmit side is valid/ready. A word that the device offers waits, with back-pressure, until the first bit time of the next owned slot; at that point ready rises for that one cycle and the word is taken. The receive side cannot stall the loop, so it has no ready. Each received word is flagged for one cycle and then held until the next owned slot completes.

Top module: `tslc_loop_coupler`

## Requirements
- R1: During reset and right after it, `line_tx`, `line_tx_vld`, `rx_valid`, `sync_err` and `tx_ready` are all 0. The coupler stays unlocked until it sees its first framing pulse.
- R2: While unlocked, every line bit is repeated, `rx_valid` stays 0 and `tx_ready` stays 0.
- R3: A framing pulse marks bit 0 of slot 0. After that, each qualified bit advances the bit count from 0 to 35. Slots count from 0 to 255 and wrap.
- R4: `cfg_share` sets the owned slots: 0 gives 1 slot (stride 256), 1 gives 8 slots (stride 32), 2 gives 16 slots (stride 16), 3 gives 32 slots (stride 8). A slot is owned when (slot − `cfg_base`) mod stride is 0. Ownership is decided at bit 0 of each slot.
- R5: In a slot that is not owned, `line_tx` equals the `line_rx` bit of the previous qualified cycle, and `line_tx_vld` pulses with it.
- R6: In an owned slot, the 36 received bits are taken MSB first, code first and operand second. One cycle after bit 35, `rx_valid` pulses for one cycle. `rx_code` and `rx_operand` then hold the word until the next owned slot completes.
- R7: `rx_kind`/`rx_code_ok` decode the code as follows: 1000 gives kind 0 (idle), 1110 gives kind 1 (load direct), 1111 gives kind 2 (load indirect), 1011 gives kind 3 (end of segment), each with ok=1. Any other code gives kind 0 with ok=0.
- R8: `tx_ready` is 1 only in the bit-0 cycle of an owned slot. If `tx_valid` is 1 then, the word `{tx_code, tx_operand}` is taken and sent MSB first, code first, one cycle later on each bit.
- R9: If no word is taken at bit 0 of an owned slot, that slot is sent as code 0000 with a zero operand.
- R10: A framing pulse at any position other than bit 0 of slot 0 while locked resets the position to bit 0 of slot 0 and pulses `sync_err` for one cycle. A pulse at the expected position, or the first pulse while unlocked, raises no error.
- R11: In a cycle with `bit_vld` low, nothing advances. The next cycle shows `line_tx_vld` 0 with `line_tx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low reset |
| bit_vld | input | 1 | This cycle carries one line bit |
| line_rx | input | 1 | Incoming line bit |
| frame_pulse | input | 1 | Framing pulse, with bit 0 of slot 0 |
| cfg_base | input | 8 | First owned slot |
| cfg_share | input | 2 | Share mode (1/8/16/32 slots) |
| line_tx | output | 1 | Outgoing line bit |
| line_tx_vld | output | 1 | `line_tx` carries a new bit |
| sync_err | output | 1 | Misplaced framing pulse seen |
| rx_valid | output | 1 | Received word available (one cycle) |
| rx_code | output | 4 | Received supervisory code |
| rx_operand | output | 32 | Received operand |
| rx_kind | output | 2 | Decoded command kind |
| rx_code_ok | output | 1 | Received code is in the command table |
| tx_valid | input | 1 | Device offers a word |
| tx_ready | output | 1 | Word taken this cycle |
| tx_code | input | 4 | Outgoing supervisory code |
| tx_operand | input | 32 | Outgoing operand |

## Verification
The hardest case to reach from the ports is a framing pulse that lands in the middle of an owned slot. At that moment a receive capture and a transmit shift are both half done, and the coupler must drop them and start again from slot 0. The stimulus sets the densest share mode with a base that owns slot 41. It lets one aligned frame start, stops after 1486 bits (bit 10 of slot 41), and then starts a new frame with a pulse. This interrupts a slot that was already carrying a device word. Idle gaps are also placed in the bit stream, so that stalls fall at arbitrary positions inside slots.

// File: rtl/tslc_pkg.sv
package tslc_pkg;
  localparam int CODE_W = 4;
  localparam int OPND_W = 32;
  localparam int WORD_W = CODE_W + OPND_W;

  typedef enum logic [1:0] {
    SHARE_1  = 2'd0,
    SHARE_8  = 2'd1,
    SHARE_16 = 2'd2,
    SHARE_32 = 2'd3
  } share_e;

  typedef enum logic [1:0] {
    DN_IDLE          = 2'd0,
    DN_LOAD_DIRECT   = 2'd1,
    DN_LOAD_INDIRECT = 2'd2,
    DN_END_SEGMENT   = 2'd3
  } dn_kind_e;

  // controller-to-device supervisory codes
  localparam logic [CODE_W-1:0] DN_CODE_IDLE     = 4'b1000;
  localparam logic [CODE_W-1:0] DN_CODE_LOAD_DIR = 4'b1110;
  localparam logic [CODE_W-1:0] DN_CODE_LOAD_IND = 4'b1111;
  localparam logic [CODE_W-1:0] DN_CODE_END_SEG  = 4'b1011;
  // device-to-controller idle code
  localparam logic [CODE_W-1:0] UP_CODE_NOP      = 4'b0000;
endpackage

// File: rtl/tslc_slot_timer.sv
module tslc_slot_timer
  import tslc_pkg::*;
#(
  parameter int SLOTS = 256,
  parameter int BITS  = WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_vld,
  input  logic                     frame_pulse,
  input  logic [$clog2(SLOTS)-1:0] cfg_base,
  input  share_e                   cfg_share,
  output logic                     own_now,
  output logic                     slot_first,
  output logic                     slot_last,
  output logic                     sync_err
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int BIT_W  = $clog2(BITS);

  logic [BIT_W-1:0]  bit_cnt;   // position of the next bit
  logic [SLOT_W-1:0] slot_cnt;
  logic              locked;
  logic              own_q;

  logic              fp;
  logic              at_expected;
  logic              lock_eff;
  logic [BIT_W-1:0]  cur_bit;
  logic [SLOT_W-1:0] cur_slot;
  logic [SLOT_W-1:0] mask;
  logic              match;

  assign fp          = frame_pulse & bit_vld;
  assign at_expected = (bit_cnt == '0) && (slot_cnt == '0);
  assign lock_eff    = locked | fp;
  assign cur_bit     = fp ? '0 : bit_cnt;
  assign cur_slot    = fp ? '0 : slot_cnt;
  assign slot_first  = (cur_bit == '0);
  assign slot_last   = (cur_bit == BIT_W'(BITS - 1));

  always_comb begin
    case (cfg_share)
      SHARE_8:  mask = SLOT_W'(SLOTS / 8 - 1);
      SHARE_16: mask = SLOT_W'(SLOTS / 16 - 1);
      SHARE_32: mask = SLOT_W'(SLOTS / 32 - 1);
      default:  mask = '1;
    endcase
  end

  assign match   = (((cur_slot - cfg_base) & mask) == '0) && lock_eff;
  assign own_now = slot_first ? match : own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      slot_cnt <= '0;
      locked   <= 1'b0;
      own_q    <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      sync_err <= 1'b0;
      if (bit_vld) begin
        locked   <= lock_eff;
        sync_err <= fp && locked && !at_expected;
        if (slot_first) own_q <= match;
        if (slot_last) begin
          bit_cnt  <= '0;
          slot_cnt <= (cur_slot == SLOT_W'(SLOTS - 1)) ? '0 : cur_slot + 1'b1;
        end else begin
          bit_cnt  <= cur_bit + 1'b1;
          slot_cnt <= cur_slot;
        end
      end
    end
  end

  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt < BIT_W'(BITS)) && (32'(slot_cnt) < SLOTS));

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> $past(frame_pulse && bit_vld));

  a_r2_no_own_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !fp) |-> !own_now);
endmodule

// File: rtl/tslc_word_shifter.sv
module tslc_word_shifter #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              line_rx,
  input  logic              own_now,
  input  logic              slot_first,
  input  logic              slot_last,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_ready,
  output logic              line_tx,
  output logic              line_tx_vld,
  output logic              rx_fire,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sr;
  logic [WORD_W-2:0] rx_sr;
  logic [WORD_W-1:0] load_word;

  assign tx_ready  = bit_vld & own_now & slot_first;
  assign load_word = tx_valid ? tx_word : '0;  // idle: code 0000, operand 0

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr       <= '0;
      rx_sr       <= '0;
      line_tx     <= 1'b0;
      line_tx_vld <= 1'b0;
      rx_fire     <= 1'b0;
      rx_word     <= '0;
    end else begin
      line_tx_vld <= bit_vld;
      rx_fire     <= 1'b0;
      if (bit_vld) begin
        if (own_now) begin
          if (slot_first) begin
            line_tx <= load_word[WORD_W-1];
            tx_sr   <= {load_word[WORD_W-2:0], 1'b0};
          end else begin
            line_tx <= tx_sr[WORD_W-1];
            tx_sr   <= {tx_sr[WORD_W-2:0], 1'b0};
          end
          rx_sr <= {rx_sr[WORD_W-3:0], line_rx};
          if (slot_last) begin
            rx_word <= {rx_sr, line_rx};
            rx_fire <= 1'b1;
          end
        end else begin
          line_tx <= line_rx;
        end
      end
    end
  end

  a_r6_fire_after_owned: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |-> $past(bit_vld && own_now && slot_last));

  a_r8_ready_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bit_vld);
endmodule

// File: rtl/tslc_code_decode.sv
module tslc_code_decode
  import tslc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output dn_kind_e          kind,
  output logic              ok
);
  always_comb begin
    ok = 1'b1;
    case (code)
      DN_CODE_IDLE:     kind = DN_IDLE;
      DN_CODE_LOAD_DIR: kind = DN_LOAD_DIRECT;
      DN_CODE_LOAD_IND: kind = DN_LOAD_INDIRECT;
      DN_CODE_END_SEG:  kind = DN_END_SEGMENT;
      default: begin
        kind = DN_IDLE;
        ok   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tslc_loop_coupler.sv
module tslc_loop_coupler
  import tslc_pkg::*;
#(
  parameter int SLOTS = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_vld,
  input  logic                     line_rx,
  input  logic                     frame_pulse,
  input  logic [$clog2(SLOTS)-1:0] cfg_base,
  input  logic [1:0]               cfg_share,
  output logic                     line_tx,
  output logic                     line_tx_vld,
  output logic                     sync_err,
  output logic                     rx_valid,
  output logic [CODE_W-1:0]        rx_code,
  output logic [OPND_W-1:0]        rx_operand,
  output logic [1:0]               rx_kind,
  output logic                     rx_code_ok,
  input  logic                     tx_valid,
  output logic                     tx_ready,
  input  logic [CODE_W-1:0]        tx_code,
  input  logic [OPND_W-1:0]        tx_operand
);
  logic              own_now;
  logic              slot_first;
  logic              slot_last;
  logic [WORD_W-1:0] rx_word;
  dn_kind_e          kind;

  tslc_slot_timer #(.SLOTS(SLOTS), .BITS(WORD_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .frame_pulse(frame_pulse),
    .cfg_base   (cfg_base),
    .cfg_share  (share_e'(cfg_share)),
    .own_now    (own_now),
    .slot_first (slot_first),
    .slot_last  (slot_last),
    .sync_err   (sync_err)
  );

  tslc_word_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld    (bit_vld),
    .line_rx    (line_rx),
    .own_now    (own_now),
    .slot_first (slot_first),
    .slot_last  (slot_last),
    .tx_valid   (tx_valid),
    .tx_word    ({tx_code, tx_operand}),
    .tx_ready   (tx_ready),
    .line_tx    (line_tx),
    .line_tx_vld(line_tx_vld),
    .rx_fire    (rx_valid),
    .rx_word    (rx_word)
  );

  assign rx_code    = rx_word[WORD_W-1:OPND_W];
  assign rx_operand = rx_word[OPND_W-1:0];

  tslc_code_decode decode_i (
    .code(rx_code),
    .kind(kind),
    .ok  (rx_code_ok)
  );

  assign rx_kind = kind;

  a_r5_repeat_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !own_now) |=> (line_tx == $past(line_rx)) && line_tx_vld);

  a_r11_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(line_tx) && !line_tx_vld);

  a_r7_legal_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_code_ok) |-> rx_code[3]);
endmodule

// File: tb/tslc_loop_coupler_tb_top.sv
module tslc_loop_coupler_tb_top;
  localparam int NSLOT = 256;
  localparam int NBIT  = 36;
  localparam int FRAME = NSLOT * NBIT;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bit_vld = 0, line_rx = 0, frame_pulse = 0;
  logic [7:0]  cfg_base = 0;
  logic [1:0]  cfg_share = 0;
  logic        line_tx, line_tx_vld, sync_err, rx_valid, rx_code_ok, tx_ready;
  logic [3:0]  rx_code;
  logic [31:0] rx_operand;
  logic [1:0]  rx_kind;
  logic        tx_valid = 0;
  logic [3:0]  tx_code = 0;
  logic [31:0] tx_operand = 0;

  always #5 clk = ~clk;

  tslc_loop_coupler dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_rx(line_rx),
    .frame_pulse(frame_pulse), .cfg_base(cfg_base), .cfg_share(cfg_share),
    .line_tx(line_tx), .line_tx_vld(line_tx_vld), .sync_err(sync_err),
    .rx_valid(rx_valid), .rx_code(rx_code), .rx_operand(rx_operand),
    .rx_kind(rx_kind), .rx_code_ok(rx_code_ok), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_code(tx_code), .tx_operand(tx_operand)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [1:0]  bit_q[$];   // {tx bit, sync_err}
  logic [35:0] rx_q[$];
  logic [35:0] tx_words[$];

  bit          m_locked = 0, m_own = 0;
  int          m_bit = 0, m_slot = 0, code_idx = 0;
  logic [35:0] m_txsr = 0, m_rxsr = 0;
  logic [3:0]  code_tbl[6] = '{4'b1000, 4'b1110, 4'b1111, 4'b1011, 4'b0101, 4'b0000};

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stride_of(input logic [1:0] s);
    case (s)
      2'd1: return 32;
      2'd2: return 16;
      2'd3: return 8;
      default: return 256;
    endcase
  endfunction

  function automatic logic [2:0] exp_decode(input logic [3:0] c); // {ok, kind}
    case (c)
      4'b1000: return 3'b100;
      4'b1110: return 3'b101;
      4'b1111: return 3'b110;
      4'b1011: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  task automatic idle_cycle();
    @(negedge clk);
    bit_vld = 0; frame_pulse = 0;
  endtask

  task automatic drive_bit(input bit fp);
    bit exp_sync = 0, exp_ready, b, t;
    logic [35:0] w;
    @(negedge clk);
    if (fp) begin
      exp_sync = m_locked && !(m_bit == 0 && m_slot == 0);
      m_locked = 1; m_bit = 0; m_slot = 0;
    end
    if (m_bit < 4) b = code_tbl[code_idx][3 - m_bit];
    else b = 1'($urandom);
    if (m_bit == 3) code_idx = (code_idx + 1) % 6;
    if (m_bit == 0)
      m_own = m_locked && (((m_slot - int'(cfg_base) + NSLOT) % stride_of(cfg_share)) == 0);
    tx_valid = (tx_words.size() > 0);
    if (tx_valid) {tx_code, tx_operand} = tx_words[0];
    bit_vld = 1; line_rx = b; frame_pulse = fp;
    exp_ready = m_own && (m_bit == 0);
    if (m_own) begin
      if (m_bit == 0) begin
        w = tx_valid ? tx_words[0] : 36'd0;   // R9 idle word
        t = w[35]; m_txsr = {w[34:0], 1'b0};
      end else begin
        t = m_txsr[35]; m_txsr = {m_txsr[34:0], 1'b0};
      end
      m_rxsr = {m_rxsr[34:0], b};
      if (m_bit == NBIT - 1) rx_q.push_back(m_rxsr);
    end else t = b;
    #1;
    check(tx_ready == exp_ready, "R8 tx_ready", tx_ready, exp_ready);
    if (exp_ready && tx_valid) void'(tx_words.pop_front());
    bit_q.push_back({t, exp_sync});
    if (m_bit == NBIT - 1) begin
      m_bit = 0; m_slot = (m_slot + 1) % NSLOT;
    end else m_bit++;
  endtask

  task automatic run_bits(input int n, input int period, input int offset);
    for (int i = 0; i < n; i++) begin
      if (i % 97 == 50) idle_cycle();          // R11 gaps
      drive_bit(period > 0 && (i % period) == offset);
    end
  endtask

  // scoreboard monitor
  logic prev_tx = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (line_tx_vld) begin
        if (bit_q.size() == 0) check(0, "R5/R8 unexpected bit", 1, 0);
        else begin
          logic [1:0] e;
          e = bit_q.pop_front();
          check(line_tx == e[1], "R5/R8/R9 line_tx", line_tx, e[1]);
          check(sync_err == e[0], "R10 sync_err", sync_err, e[0]);
        end
      end else begin
        check(line_tx == prev_tx, "R11 line_tx hold", line_tx, prev_tx);
        check(sync_err == 0, "R10 sync_err idle", sync_err, 0);
      end
      prev_tx = line_tx;
      if (rx_valid) begin
        if (rx_q.size() == 0) check(0, "R6 unexpected rx_valid", 1, 0);
        else begin
          logic [35:0] e;
          logic [2:0]  d;
          e = rx_q.pop_front();
          d = exp_decode(e[35:32]);
          check({rx_code, rx_operand} == e, "R6 rx word", {rx_code, rx_operand}, e);
          check({rx_code_ok, rx_kind} == d, "R7 decode", {rx_code_ok, rx_kind}, d);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check({line_tx, line_tx_vld, rx_valid, sync_err, tx_ready} == 5'b0, "R1 reset outputs",
          {line_tx, line_tx_vld, rx_valid, sync_err, tx_ready}, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check({line_tx, line_tx_vld, rx_valid, sync_err} == 4'b0, "R1 after reset",
          {line_tx, line_tx_vld, rx_valid, sync_err}, 0);

    // R2 unlocked: everything repeated
    cfg_share = 2'd0; cfg_base = 8'd5;
    tx_words.push_back({4'b0101, 32'hCAFE_0001});
    run_bits(500, 0, 0);

    // R3/R4 one slot per frame, first lock then an expected pulse
    run_bits(FRAME, FRAME, 0);
    run_bits(FRAME, FRAME, 0);
    check(tx_words.size() == 0, "R8 word taken in single slot", tx_words.size(), 0);

    // R4 eight slots
    cfg_share = 2'd1; cfg_base = 8'd3;
    for (int k = 0; k < 3; k++) tx_words.push_back({4'b0010, 32'h1000_0000 + k});
    run_bits(FRAME, FRAME, 0);

    // R4 sixteen slots, more words than slots
    cfg_share = 2'd2; cfg_base = 8'd15;
    for (int k = 0; k < 20; k++) tx_words.push_back({4'b0110, 32'h2000_0000 + k});
    run_bits(FRAME, FRAME, 0);
    check(tx_words.size() == 4, "R8 back-pressure leftover", tx_words.size(), 4);

    // R4 thirty-two slots
    cfg_share = 2'd3; cfg_base = 8'd7;
    run_bits(FRAME, FRAME, 0);
    check(tx_words.size() == 0, "R8 leftovers drained", tx_words.size(), 0);

    // R10 misplaced pulse in the middle of owned slot 41
    cfg_base = 8'd1;
    tx_words.push_back({4'b0011, 32'hDEAD_BEEF});
    tx_words.push_back({4'b0111, 32'h0BAD_F00D});
    run_bits(41 * NBIT + 10, 41 * NBIT + 10, 0);
    run_bits(FRAME, FRAME, 0);
    run_bits(NBIT * 4, FRAME, 0);   // pulse at expected position

    repeat (4) idle_cycle();
    repeat (3) @(negedge clk);
    check(bit_q.size() == 0, "R5 all bits seen", bit_q.size(), 0);
    check(rx_q.size() == 0, "R6 all words received", rx_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule